// File: doc/BRIEF.md
# Partitioned Packed-Integer ALU with Byte Absolute-Difference Accumulation

This unit is a 64-bit packed-integer execution unit. A lane-size code splits each operand into eight 8-bit, four 16-bit or two 32-bit elements. On that split it adds and subtracts per lane with wraparound, and it compares per lane for equality or signed greater-than, writing one mask per lane. It also converts between element widths. Pack narrows the wide elements of both operands with unsigned saturation. Expand zero-extends the narrow elements found in the low half of the first operand.

The unit also has a pixel-distance operation for motion search. Each issue takes eight unsigned byte pairs, sums their absolute differences and adds that sum to a 16-bit running accumulator. A 16x16 block takes 32 issues. The largest possible block total is 65280, so it always fits in the accumulator. A clear flag sent with an issue starts a new block.

Every operation flows through the same three-stage in-order pipeline. There is a valid/ready handshake on the input side and another on the output side. When the output is held, the whole pipeline stalls.

Top module: `simd_px_unit`

## Requirements
- R1: With `op`=0, each lane of `result` is the wraparound sum of the matching lanes of `srcA` and `srcB`. No carry crosses a lane boundary. `laneSize` 0 selects 8-bit lanes, 1 selects 16-bit lanes, and 2 or 3 select 32-bit lanes.
- R2: With `op`=1, each lane is `srcA` minus `srcB` with wraparound. No borrow crosses a lane boundary.
- R3: With `op`=2, each lane of `result` is all ones when the two lanes are equal and all zeros otherwise.
- R4: With `op`=3, each lane of `result` is all ones when the `srcA` lane is greater than the `srcB` lane as a two's-complement number, and all zeros otherwise.
- R5: With `op`=4, `laneSize` selects the narrow width N (8, 16 or 32). Each 2N-bit element of `srcA` is treated as unsigned, saturates to the N-bit maximum, and is placed in order into bits 31:0. The elements of `srcB` are placed the same way into bits 63:32.
- R6: With `op`=5, each N-bit element in `srcA[31:0]` is zero-extended to 2N bits. Element k goes to bits k*2N upward.
- R7: With `op`=6, the sum of |a-b| over the eight unsigned byte pairs is added to the accumulator. `result[15:0]` is the new accumulator value and `result[63:16]` is zero.
- R8: `clrAcc` set on an `op`=6 issue makes the sum start from zero. `clrAcc` on any other op leaves the accumulator unchanged.
- R9: Thirty-two issues of maximal byte differences accumulate to 65280 without loss.
- R10: When the output is not stalled, a result is presented with `outValid` on the third clock edge, counting the edge that accepted the operation. Results leave in issue order.
- R11: While `outValid` is high and `outReady` is low, `outValid` and `result` hold. Once the pipeline is full, `inReady` goes low.
- R12: After reset, `outValid` is low, `inReady` is high and the accumulator is zero.
- R13: `op`=7 returns an all-zero `result` and does not touch the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation offered |
| inReady | output | 1 | Operation accepted when high with inValid |
| op | input | 3 | Operation code |
| laneSize | input | 2 | Lane size (narrow width for pack and expand) |
| clrAcc | input | 1 | Restart the accumulator with this pixel-distance issue |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| outValid | output | 1 | Result available |
| outReady | input | 1 | Consumer takes result |
| result | output | 64 | Operation result |

## Verification
The add and subtract patterns put all-ones next to lane boundaries, so a carry or borrow that leaks into the next lane shows up for each lane size. The compare operands straddle the sign bit, which separates a signed compare from an unsigned one. The pack inputs sit just below, exactly at and above the saturation limit. Pixel-distance runs cover a cleared start, a continued block, a clear sent with a non-pixel op, and a full 32-issue block at the maximum difference. A mixed stream under pseudo-random backpressure, together with one held stall, shows that results keep their order and are never lost or duplicated.

// File: rtl/simd_pkg.sv
package simd_pkg;

  typedef enum logic [2:0] {
    OP_ADD    = 3'd0,
    OP_SUB    = 3'd1,
    OP_CMPEQ  = 3'd2,
    OP_CMPGT  = 3'd3,
    OP_PACK   = 3'd4,
    OP_EXPAND = 3'd5,
    OP_PXDIST = 3'd6,
    OP_NONE   = 3'd7
  } simdOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic shift;     // whole pipeline advances this cycle
    logic accWrite;  // stage two holds a valid pixel-distance sum
    logic accZero;   // that sum restarts the accumulator
    logic selSad;    // output register takes the accumulator
  } stageStrobe_t;

endpackage

// File: rtl/simd_lane_ops.sv
// Compare, pack and expand for one fixed element width EW.
module simd_lane_ops #(
  parameter int DATA_W = 64,
  parameter int EW     = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  output logic [DATA_W-1:0] eqMask,
  output logic [DATA_W-1:0] gtMask,
  output logic [DATA_W-1:0] packOut,
  output logic [DATA_W-1:0] expandOut
);
  localparam int NLANE = DATA_W / EW;
  localparam int HALF  = DATA_W / 2;
  localparam int NSRC  = HALF / EW;   // wide elements per operand for pack
  localparam int NEXP  = HALF / EW;   // narrow elements expanded

  for (genvar l = 0; l < NLANE; l++) begin : gLane
    assign eqMask[l*EW +: EW] = (opA[l*EW +: EW] == opB[l*EW +: EW]) ? {EW{1'b1}} : {EW{1'b0}};
    assign gtMask[l*EW +: EW] =
      ($signed(opA[l*EW +: EW]) > $signed(opB[l*EW +: EW])) ? {EW{1'b1}} : {EW{1'b0}};
  end

  for (genvar k = 0; k < NSRC; k++) begin : gPack
    logic [2*EW-1:0] wideA, wideB;
    assign wideA = opA[k*2*EW +: 2*EW];
    assign wideB = opB[k*2*EW +: 2*EW];
    assign packOut[k*EW +: EW]        = (|wideA[2*EW-1:EW]) ? {EW{1'b1}} : wideA[EW-1:0];
    assign packOut[HALF + k*EW +: EW] = (|wideB[2*EW-1:EW]) ? {EW{1'b1}} : wideB[EW-1:0];
  end

  for (genvar k = 0; k < NEXP; k++) begin : gExpand
    assign expandOut[k*2*EW +: 2*EW] = {{EW{1'b0}}, opA[k*EW +: EW]};
  end

endmodule

// File: rtl/simd_ctrl.sv
// Pipeline occupancy, stall and accumulator strobes.
module simd_ctrl
  import simd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  input  logic         outReady,
  input  simdOp_e      op,
  input  logic         clrAcc,
  output logic         inReady,
  output logic         outValid,
  output stageStrobe_t strobes
);
  logic v1, v2, v3;
  logic sad1, sad2;
  logic clr1, clr2;
  logic shift;

  assign shift    = !v3 || outReady;
  assign inReady  = shift;
  assign outValid = v3;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      v1   <= 1'b0;
      v2   <= 1'b0;
      v3   <= 1'b0;
      sad1 <= 1'b0;
      sad2 <= 1'b0;
      clr1 <= 1'b0;
      clr2 <= 1'b0;
    end else if (shift) begin
      v1   <= inValid;
      sad1 <= inValid && (op == OP_PXDIST);
      clr1 <= clrAcc;
      v2   <= v1;
      sad2 <= sad1;
      clr2 <= clr1;
      v3   <= v2;
    end
  end

  always_comb begin
    strobes          = '0;
    strobes.shift    = shift;
    strobes.accWrite = shift && v2 && sad2;
    strobes.accZero  = clr2;
    strobes.selSad   = sad2;
  end

  // R11: a presented result is not withdrawn while the consumer stalls
  assert_hold_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> outValid);

endmodule

// File: rtl/simd_datapath.sv
// Lane arithmetic, absolute differences, reduction and accumulator.
module simd_datapath
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PIX_W  = 8,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  stageStrobe_t      strobes,
  input  simdOp_e           op,
  input  logic [1:0]        laneSize,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] result
);
  localparam int NPIX     = DATA_W / PIX_W;
  localparam int SUM_W    = PIX_W + $clog2(NPIX);
  localparam int NWID     = 3;
  localparam int ONE_MAX  = NPIX * ((1 << PIX_W) - 1);

  // ---------------- stage 0: combinational lane operations
  logic [1:0]        wIdx;
  logic [DATA_W-1:0] eqW     [NWID];
  logic [DATA_W-1:0] gtW     [NWID];
  logic [DATA_W-1:0] packW   [NWID];
  logic [DATA_W-1:0] expandW [NWID];

  assign wIdx = (laneSize == 2'd3) ? 2'd2 : laneSize;

  for (genvar g = 0; g < NWID; g++) begin : gWidth
    simd_lane_ops #(.DATA_W(DATA_W), .EW(PIX_W << g)) uOps (
      .opA      (srcA),
      .opB      (srcB),
      .eqMask   (eqW[g]),
      .gtMask   (gtW[g]),
      .packOut  (packW[g]),
      .expandOut(expandW[g])
    );
  end

  // add / subtract with the carry chain cut at each lane start
  logic [NPIX-1:0]   laneStart;
  logic [DATA_W-1:0] addRes;
  logic [DATA_W-1:0] bOperand;
  logic              isSub;

  assign isSub    = (op == OP_SUB);
  assign bOperand = isSub ? ~srcB : srcB;

  always_comb begin
    int span;
    span = 1 << wIdx;
    for (int i = 0; i < NPIX; i++) laneStart[i] = ((i % span) == 0);
  end

  always_comb begin
    logic         cy;
    logic [PIX_W:0] t;
    cy = 1'b0;
    t  = '0;
    for (int i = 0; i < NPIX; i++) begin
      if (laneStart[i]) cy = isSub;
      t = {1'b0, srcA[i*PIX_W +: PIX_W]} + {1'b0, bOperand[i*PIX_W +: PIX_W]}
          + {{PIX_W{1'b0}}, cy};
      addRes[i*PIX_W +: PIX_W] = t[PIX_W-1:0];
      cy = t[PIX_W];
    end
  end

  logic [DATA_W-1:0] laneRes;
  always_comb begin
    case (op)
      OP_ADD, OP_SUB: laneRes = addRes;
      OP_CMPEQ:       laneRes = eqW[wIdx];
      OP_CMPGT:       laneRes = gtW[wIdx];
      OP_PACK:        laneRes = packW[wIdx];
      OP_EXPAND:      laneRes = expandW[wIdx];
      default:        laneRes = '0;
    endcase
  end

  // byte absolute differences
  logic [PIX_W-1:0] diff0 [NPIX];
  always_comb begin
    for (int i = 0; i < NPIX; i++) begin
      if (srcA[i*PIX_W +: PIX_W] > srcB[i*PIX_W +: PIX_W])
        diff0[i] = srcA[i*PIX_W +: PIX_W] - srcB[i*PIX_W +: PIX_W];
      else
        diff0[i] = srcB[i*PIX_W +: PIX_W] - srcA[i*PIX_W +: PIX_W];
    end
  end

  // ---------------- stage 1 registers
  logic [DATA_W-1:0] lane1;
  logic [PIX_W-1:0]  diff1 [NPIX];
  simdOp_e           s1Op;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lane1 <= '0;
      s1Op  <= OP_ADD;
      for (int i = 0; i < NPIX; i++) diff1[i] <= '0;
    end else if (strobes.shift) begin
      lane1 <= laneRes;
      s1Op  <= op;
      for (int i = 0; i < NPIX; i++) diff1[i] <= diff0[i];
    end
  end

  // reduction tree of the eight differences
  logic [SUM_W-1:0] sum1;
  always_comb begin
    sum1 = '0;
    for (int i = 0; i < NPIX; i++) sum1 = sum1 + SUM_W'(diff1[i]);
  end

  // ---------------- stage 2 registers
  logic [DATA_W-1:0] lane2;
  logic [SUM_W-1:0]  sum2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lane2 <= '0;
      sum2  <= '0;
    end else if (strobes.shift) begin
      lane2 <= lane1;
      sum2  <= sum1;
    end
  end

  // ---------------- stage 3: accumulate and present
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  accNext;
  logic [DATA_W-1:0] resReg;

  assign accNext = (strobes.accZero ? '0 : acc) + ACC_W'(sum2);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) acc <= '0;
    else if (strobes.accWrite) acc <= accNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resReg <= '0;
    else if (strobes.shift)
      resReg <= strobes.selSad ? {{(DATA_W-ACC_W){1'b0}}, accNext} : lane2;
  end

  assign result = resReg;

  // ---------------- checks
  logic cmpBytesOk;
  always_comb begin
    cmpBytesOk = 1'b1;
    for (int i = 0; i < NPIX; i++)
      if (lane1[i*PIX_W +: PIX_W] != '0 && lane1[i*PIX_W +: PIX_W] != '1) cmpBytesOk = 1'b0;
  end

  // R3 and R4: compare results are whole-lane masks
  assert_cmp_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
    (s1Op == OP_CMPEQ || s1Op == OP_CMPGT) |-> cmpBytesOk);

  // R8, R13: only a pixel-distance issue moves the accumulator
  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accWrite |=> $stable(acc));

  // R8: a restarted block holds no more than one issue's maximum
  assert_clear_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.accWrite && strobes.accZero) |=> (acc <= ACC_W'(ONE_MAX)));

  // R7: the upper part of a pixel-distance result is zero
  assert_sad_upper_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.shift && strobes.selSad) |=> (resReg[DATA_W-1:ACC_W] == '0));

endmodule

// File: rtl/simd_px_unit.sv
module simd_px_unit
  import simd_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int PIX_W  = 8,
  parameter int ACC_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        op,
  input  logic [1:0]        laneSize,
  input  logic              clrAcc,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] result
);
  simdOp_e      opCode;
  stageStrobe_t strobes;

  assign opCode = simdOp_e'(op);

  simd_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .outReady(outReady),
    .op      (opCode),
    .clrAcc  (clrAcc),
    .inReady (inReady),
    .outValid(outValid),
    .strobes (strobes)
  );

  simd_datapath #(.DATA_W(DATA_W), .PIX_W(PIX_W), .ACC_W(ACC_W)) uData (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .op      (opCode),
    .laneSize(laneSize),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result)
  );

  // R11: data held while the consumer stalls
  assert_hold_result_R11: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> $stable(result));

endmodule

// File: tb/sim_simd_px_unit.sv
`timescale 1ns/1ps
module sim_simd_px_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [2:0]  op = '0;
  logic [1:0]  laneSize = '0;
  logic        clrAcc = 1'b0;
  logic [63:0] srcA = '0;
  logic [63:0] srcB = '0;
  logic        outValid;
  logic        outReady;
  logic [63:0] result;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  int mode = 0;           // 0 ready, 1 stalled, 2 pseudo-random
  int lastAcceptCyc = 0;
  int lastPopCyc = 0;
  logic [15:0] modelAcc = '0;
  logic [63:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;   // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  simd_px_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .op(op), .laneSize(laneSize), .clrAcc(clrAcc), .srcA(srcA), .srcB(srcB),
    .outValid(outValid), .outReady(outReady), .result(result)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] msk(input int w);
    return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
  endfunction

  function automatic logic [63:0] modelLane(input int o, input int ls, input logic [63:0] a, input logic [63:0] b);
    int w;
    logic [63:0] r, m, m2, ea, eb, sb;
    w = (ls == 0) ? 8 : (ls == 1) ? 16 : 32;
    m = msk(w); m2 = msk(2*w); r = '0;
    case (o)
      0, 1: for (int k = 0; k < 64/w; k++) begin
              ea = (a >> (k*w)) & m; eb = (b >> (k*w)) & m;
              r |= (((o == 0) ? ea + eb : ea - eb) & m) << (k*w);
            end
      2: for (int k = 0; k < 64/w; k++)
           if (((a >> (k*w)) & m) == ((b >> (k*w)) & m)) r |= m << (k*w);
      3: begin
           sb = 64'd1 << (w-1);
           for (int k = 0; k < 64/w; k++) begin
             ea = (a >> (k*w)) & m; eb = (b >> (k*w)) & m;
             if ((ea ^ sb) > (eb ^ sb)) r |= m << (k*w);
           end
         end
      4: for (int k = 0; k < 32/w; k++) begin
           ea = (a >> (k*2*w)) & m2; eb = (b >> (k*2*w)) & m2;
           r |= ((ea > m) ? m : ea) << (k*w);
           r |= ((eb > m) ? m : eb) << (32 + k*w);
         end
      5: for (int k = 0; k < 32/w; k++) r |= ((a >> (k*w)) & m) << (k*2*w);
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic logic [15:0] sadOf(input logic [63:0] a, input logic [63:0] b);
    logic [15:0] s;
    logic [7:0] x, y;
    s = '0;
    for (int i = 0; i < 8; i++) begin
      x = a[i*8 +: 8]; y = b[i*8 +: 8];
      s += (x > y) ? 16'(x - y) : 16'(y - x);
    end
    return s;
  endfunction

  // driver: called at a falling edge, returns at a falling edge
  task automatic issue(input int o, input int ls, input logic [63:0] a, input logic [63:0] b,
                       input bit clr, input string tag);
    logic [63:0] e;
    if (o == 6) begin
      modelAcc = (clr ? 16'd0 : modelAcc) + sadOf(a, b);
      e = {48'd0, modelAcc};
    end else e = modelLane(o, ls, a, b);
    expQ.push_back(e);
    tagQ.push_back(tag);
    op = 3'(o); laneSize = 2'(ls); srcA = a; srcB = b; clrAcc = clr; inValid = 1'b1;
    forever begin
      #1;
      if (inReady) begin lastAcceptCyc = cyc; break; end
      @(negedge clk);
    end
    @(negedge clk);
    inValid = 1'b0; clrAcc = 1'b0;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // backpressure source
  initial begin
    logic [7:0] lf;
    lf = 8'h5a;
    outReady = 1'b1;
    forever begin
      @(negedge clk);
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      case (mode)
        0: outReady = 1'b1;
        1: outReady = 1'b0;
        default: outReady = lf[0] | lf[3];
      endcase
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rstN && outValid && outReady) begin
        if (expQ.size() == 0) chk(1'b0, "R10 unexpected result", result, '0);
        else begin
          chk(result === expQ[0], tagQ[0], result, expQ[0]);
          void'(expQ.pop_front()); void'(tagQ.pop_front());
        end
        lastPopCyc = cyc;
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=%0d expected=0", expQ.size());
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [63:0] held, x, y;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk(outValid == 1'b0, "R12 outValid", 64'(outValid), 64'd0);
    chk(inReady == 1'b1, "R12 inReady", 64'(inReady), 64'd1);
    @(negedge clk);

    // R12 accumulator starts at zero; R7 sum of differences
    issue(6, 0, 64'h0010_FF00_0305_7F80, 64'h0020_00FF_0503_807F, 1'b0, "R12 first sum");
    issue(6, 0, 64'hFF00_FF00_FF00_FF00, 64'h00FF_00FF_00FF_00FF, 1'b0, "R7 continue");

    // R1 add with carry at lane edges
    for (int ls = 0; ls < 4; ls++) begin
      issue(0, ls, 64'h80FF_7FFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 1'b0, "R1 add");
      issue(0, ls, 64'hFFFF_FFFF_0000_FFFF, 64'h0000_0001_FFFF_0001, 1'b0, "R1 add edge");
    end
    // R2 subtract with borrow at lane edges
    for (int ls = 0; ls < 3; ls++) begin
      issue(1, ls, 64'h0000_0000_0100_0000, 64'h0001_0001_0001_0001, 1'b0, "R2 sub");
      issue(1, ls, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0, "R2 sub edge");
    end
    // R3, R4 compares around the sign bit
    for (int ls = 0; ls < 3; ls++) begin
      issue(2, ls, 64'h1234_5678_0000_FFFF, 64'h1234_5679_0000_FFFF, 1'b0, "R3 equal");
      issue(3, ls, 64'h8000_7F00_0180_FF01, 64'h7FFF_8000_0080_0102, 1'b0, "R4 signed gt");
    end
    // R5 pack with saturation
    issue(4, 0, 64'h0100_00FF_0080_FFFF, 64'h00FE_0000_0101_0001, 1'b0, "R5 pack 8");
    issue(4, 1, 64'h0001_0000_0000_FFFF, 64'h0000_FFFF_0000_8000, 1'b0, "R5 pack 16");
    issue(4, 2, 64'h0000_0000_FFFF_FFFF, 64'h0000_0001_0000_0000, 1'b0, "R5 pack 32");
    // R6 expand
    for (int ls = 0; ls < 3; ls++)
      issue(5, ls, 64'hDEAD_BEEF_8001_7FFE, 64'h1111_2222_3333_4444, 1'b0, "R6 expand");
    // R13 reserved op, R8 clear on non-pixel op ignored
    issue(7, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 1'b1, "R13 reserved");
    issue(0, 1, 64'h5, 64'h6, 1'b1, "R8 clr on add");
    issue(6, 0, 64'h0000_0000_0000_0009, 64'h0, 1'b0, "R8 accumulator kept");
    issue(6, 0, 64'h0102_0304_0506_0708, 64'h0807_0605_0403_0201, 1'b1, "R8 restart");

    // R9 full block at maximal difference
    for (int i = 0; i < 32; i++)
      issue(6, 0, (i % 2) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h0, (i % 2) ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF,
            (i == 0), "R9 block");
    drain();
    chk(modelAcc == 16'd65280, "R9 model total", 64'(modelAcc), 64'd65280);

    // R10 latency
    issue(0, 0, 64'h1, 64'h2, 1'b0, "R10 latency data");
    drain();
    chk((lastPopCyc - lastAcceptCyc) == 3, "R10 latency", 64'(lastPopCyc - lastAcceptCyc), 64'd3);

    // R11 stall holds result and blocks input
    mode = 1;
    repeat (2) @(negedge clk);
    fork
      begin
        for (int i = 0; i < 5; i++)
          issue(i % 2, 0, 64'h0101_0101_0101_0101 * 64'(i + 1), 64'h0F0F_0F0F_0F0F_0F0F, 1'b0, "R11 stalled item");
      end
    join_none
    repeat (10) @(negedge clk);
    #1;
    chk(inReady == 1'b0, "R11 inReady low", 64'(inReady), 64'd0);
    chk(outValid == 1'b1, "R11 outValid held", 64'(outValid), 64'd1);
    held = result;
    chk(held === expQ[0], "R11 head value", held, expQ[0]);
    repeat (3) @(negedge clk);
    #1;
    chk(result === held, "R11 result stable", result, held);
    @(negedge clk);
    mode = 0;
    wait fork;
    drain();

    // R10 ordering under random backpressure
    mode = 2;
    x = 64'h0123_4567_89AB_CDEF;
    y = 64'hFEDC_BA98_7654_3210;
    for (int i = 0; i < 48; i++) begin
      x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
      y = y ^ (y << 11); y = y ^ (y >> 9); y = y ^ (y << 19);
      issue(i % 8, i % 4, x, y, (i % 16) == 6, "R10 mixed stream");
    end
    mode = 0;
    drain();

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule